// File: doc/BRIEF.md
# Asynchronous Memory Access Sequencer

This block turns single read or write requests from one internal requester into timed cycles on an asynchronous external memory bus. The bus has a 24-bit address, an active-low select, active-low read and write strobes, a 32-bit data output with its own output enable, and a 32-bit data input. A 32-bit configuration word sets the timing. Its fields are the wait states, which lengthen the strobe, the bus hold cycles, which add quiet cycles after every access, and the read hold cycles, which add a delay between two reads while the address stays put.

Each access goes through the same steps. An optional lead-in comes first: read hold cycles before a read that follows a read, or one idle turnaround cycle before a write that follows a read. Then the strobe phase runs, and after it the optional bus hold phase. After the last cycle the block drops back to idle and pulses done. The block samples the configuration word when it accepts a request, so a change made during an access has no effect on that access. Read data is captured on the last strobe cycle and stays on the read-data output until the next read.

Top module: `amem_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1, mem_sel_n, mem_rd_n and mem_wr_n are 1, and mem_doe and rsp_done are 0.
- R2: A read drives mem_rd_n and mem_sel_n low for 1+W consecutive cycles, where W is cfg[10:6]. mem_din is captured in the last of those cycles and is presented on rsp_rdata when rsp_done is 1.
- R3: A write drives mem_wr_n and mem_sel_n low for 1+W cycles, with mem_dout equal to the request's write data. mem_doe is 1 in the write strobe cycles and in the bus hold cycles of that write, and 0 in every other cycle.
- R4: After the strobe phase of every access come exactly B cycles, where B is cfg[13:11]. In these cycles no strobe and no select are active and the address keeps the access's value. B=0 adds no cycles.
- R5: A read accepted when the previous completed access was a read waits H cycles before its strobe, where H is cfg[20:18]. In these cycles there is no strobe or select, and mem_addr keeps the previous access's address. H=0 disables the wait. The wait never applies after a write or to the first access after reset.
- R6: A write accepted when the previous completed access was a read is preceded by exactly one cycle with no strobe, no select, mem_doe at 0 and mem_addr unchanged. Other pairs of accesses get no such cycle.
- R7: A request is accepted only in a cycle where req_valid and req_ready are both 1. req_ready stays 0 from the cycle after acceptance until the access ends, and req_valid during that time has no effect. rsp_done is a single-cycle pulse in the first cycle in which req_ready is 1 again.
- R8: mem_rd_n and mem_wr_n are never low together, and mem_addr does not change while mem_sel_n is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 32 | Timing configuration: wait states [10:6], bus hold [13:11], read hold [20:18] |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 24 | Request address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Block idle and able to accept a request |
| rsp_done | output | 1 | One-cycle access-complete pulse |
| rsp_rdata | output | 32 | Data captured by the most recent read |
| mem_addr | output | 24 | External address bus |
| mem_sel_n | output | 1 | Memory select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_dout | output | 32 | Data driven toward memory |
| mem_doe | output | 1 | Output enable for mem_dout |
| mem_din | input | 32 | Data returned by memory |

## Verification
The assertions assume that strobes from two different accesses are always separated by at least one cycle with the select inactive. The address-stability property depends on this, and the sequencer guarantees it through the idle cycle that carries done. They also assume that mem_din has settled by the end of the last strobe cycle. The bench meets this with a memory model that returns a fixed function of mem_addr with no delay. The stimulus sweeps every combination of small wait, bus hold and read hold values. It fills the unused configuration bits with ones, and runs access sequences that contain every ordered pair of read and write. For half of the accesses it keeps req_valid high with a conflicting payload while the block is busy.

// File: rtl/amem_pkg.sv
package amem_pkg;

    // Phases of one access; ST_IDLE must stay the all-zero code.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RHOLD  = 3'd1,
        ST_TURN   = 3'd2,
        ST_STROBE = 3'd3,
        ST_BHOLD  = 3'd4
    } amem_state_e;

endpackage

// File: rtl/amem_cfg_dec.sv
module amem_cfg_dec #(
    parameter int CFG_W  = 32,
    parameter int WS_LSB = 6,
    parameter int WS_W   = 5,
    parameter int BH_LSB = 11,
    parameter int BH_W   = 3,
    parameter int RH_LSB = 18,
    parameter int RH_W   = 3
) (
    input  logic [CFG_W-1:0] cfg_word,
    output logic [WS_W-1:0]  wait_cnt,
    output logic [BH_W-1:0]  bus_hold,
    output logic [RH_W-1:0]  rd_hold
);
    assign wait_cnt = cfg_word[WS_LSB +: WS_W];
    assign bus_hold = cfg_word[BH_LSB +: BH_W];
    assign rd_hold  = cfg_word[RH_LSB +: RH_W];
endmodule

// File: rtl/amem_phase_cnt.sv
module amem_phase_cnt #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             at_zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/amem_seq.sv
module amem_seq
    import amem_pkg::*;
#(
    parameter int AW     = 24,
    parameter int DW     = 32,
    parameter int CFG_W  = 32,
    parameter int WS_LSB = 6,
    parameter int WS_W   = 5,
    parameter int BH_LSB = 11,
    parameter int BH_W   = 3,
    parameter int RH_LSB = 18,
    parameter int RH_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             req_ready,
    output logic             rsp_done,
    output logic [DW-1:0]    rsp_rdata,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_sel_n,
    output logic             mem_rd_n,
    output logic             mem_wr_n,
    output logic [DW-1:0]    mem_dout,
    output logic             mem_doe,
    input  logic [DW-1:0]    mem_din
);
    localparam int BR_W  = (BH_W > RH_W) ? BH_W : RH_W;
    localparam int CNT_W = (WS_W > BR_W) ? WS_W : BR_W;

    typedef struct packed {
        amem_state_e     state;
        logic [AW-1:0]   addr;
        logic [AW-1:0]   pend_addr;
        logic [DW-1:0]   dout;
        logic [DW-1:0]   rdata;
        logic            doe;
        logic            sel_n;
        logic            rd_n;
        logic            wr_n;
        logic            done;
        logic            last_rd;
        logic            is_wr;
        logic [WS_W-1:0] ws;
        logic [BH_W-1:0] bh;
    } seq_t;

    seq_t r_d, r_q;

    logic [WS_W-1:0]  dec_ws;
    logic [BH_W-1:0]  dec_bh;
    logic [RH_W-1:0]  dec_rh;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_zero;

    logic             go_strobe;
    logic [AW-1:0]    go_addr;
    logic             go_wr;
    logic [WS_W-1:0]  go_ws;
    logic             go_finish;

    amem_cfg_dec #(
        .CFG_W (CFG_W),
        .WS_LSB(WS_LSB), .WS_W(WS_W),
        .BH_LSB(BH_LSB), .BH_W(BH_W),
        .RH_LSB(RH_LSB), .RH_W(RH_W)
    ) cfg_dec_i (
        .cfg_word(cfg_word),
        .wait_cnt(dec_ws),
        .bus_hold(dec_bh),
        .rd_hold (dec_rh)
    );

    amem_phase_cnt #(
        .CNT_W(CNT_W)
    ) phase_cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_val),
        .at_zero (cnt_zero)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        cnt_load  = 1'b0;
        cnt_val   = '0;
        go_strobe = 1'b0;
        go_addr   = r_q.pend_addr;
        go_wr     = r_q.is_wr;
        go_ws     = r_q.ws;
        go_finish = 1'b0;

        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    // latch the request and the timing fields together
                    r_d.is_wr     = req_write;
                    r_d.pend_addr = req_addr;
                    r_d.dout      = req_wdata;
                    r_d.ws        = dec_ws;
                    r_d.bh        = dec_bh;
                    if (!req_write && r_q.last_rd && (dec_rh != '0)) begin
                        r_d.state = ST_RHOLD;
                        cnt_load  = 1'b1;
                        cnt_val   = CNT_W'(dec_rh) - CNT_W'(1);
                    end else if (req_write && r_q.last_rd) begin
                        r_d.state = ST_TURN;
                    end else begin
                        go_strobe = 1'b1;
                        go_addr   = req_addr;
                        go_wr     = req_write;
                        go_ws     = dec_ws;
                    end
                end
            end
            ST_RHOLD: begin
                if (cnt_zero) begin
                    go_strobe = 1'b1;
                end
            end
            ST_TURN: begin
                go_strobe = 1'b1;
            end
            ST_STROBE: begin
                if (cnt_zero) begin
                    r_d.sel_n = 1'b1;
                    r_d.rd_n  = 1'b1;
                    r_d.wr_n  = 1'b1;
                    if (!r_q.is_wr) begin
                        r_d.rdata = mem_din;
                    end
                    if (r_q.bh != '0) begin
                        r_d.state = ST_BHOLD;
                        cnt_load  = 1'b1;
                        cnt_val   = CNT_W'(r_q.bh) - CNT_W'(1);
                    end else begin
                        go_finish = 1'b1;
                    end
                end
            end
            ST_BHOLD: begin
                if (cnt_zero) begin
                    go_finish = 1'b1;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase

        if (go_strobe) begin
            r_d.state = ST_STROBE;
            r_d.addr  = go_addr;
            r_d.sel_n = 1'b0;
            r_d.rd_n  = go_wr;
            r_d.wr_n  = !go_wr;
            r_d.doe   = go_wr;
            cnt_load  = 1'b1;
            cnt_val   = CNT_W'(go_ws);
        end

        if (go_finish) begin
            r_d.state   = ST_IDLE;
            r_d.doe     = 1'b0;
            r_d.done    = 1'b1;
            r_d.last_rd = !r_q.is_wr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.sel_n <= 1'b1;
            r_q.rd_n  <= 1'b1;
            r_q.wr_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.state == ST_IDLE);
    assign rsp_done  = r_q.done;
    assign rsp_rdata = r_q.rdata;
    assign mem_addr  = r_q.addr;
    assign mem_sel_n = r_q.sel_n;
    assign mem_rd_n  = r_q.rd_n;
    assign mem_wr_n  = r_q.wr_n;
    assign mem_dout  = r_q.dout;
    assign mem_doe   = r_q.doe;

endmodule

// File: rtl/amem_seq_chk.sv
module amem_seq_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_done,
    input logic [AW-1:0] mem_addr,
    input logic          mem_sel_n,
    input logic          mem_rd_n,
    input logic          mem_wr_n,
    input logic          mem_doe
);
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));

    // R2
    sel_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n || !mem_wr_n) |-> !mem_sel_n);

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_sel_n |=> (mem_sel_n || $stable(mem_addr)));

    // R3
    doe_not_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_doe |-> mem_rd_n);

    // R7
    busy_while_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n || !mem_wr_n) |-> !req_ready);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R7
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);

    // R6
    rd_then_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_n) |=> mem_wr_n);
endmodule

bind amem_seq amem_seq_chk #(.AW(AW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .rsp_done (rsp_done),
    .mem_addr (mem_addr),
    .mem_sel_n(mem_sel_n),
    .mem_rd_n (mem_rd_n),
    .mem_wr_n (mem_wr_n),
    .mem_doe  (mem_doe)
);

// File: tb/amem_seq_tb_top.sv
module amem_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_done;
    logic [31:0] rsp_rdata;
    logic [23:0] mem_addr;
    logic        mem_sel_n, mem_rd_n, mem_wr_n, mem_doe;
    logic [31:0] mem_dout, mem_din;

    int errs = 0;
    int checks = 0;
    bit prev_rd = 1'b0;
    logic [23:0] prev_addr = '0;

    always #5 clk = ~clk;

    // memory model: data is a fixed function of the address
    assign mem_din = {mem_addr[7:0] ^ 8'h5A, mem_addr};

    amem_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .mem_dout(mem_dout), .mem_doe(mem_doe),
        .mem_din(mem_din)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(bit wr, logic [23:0] a, logic [31:0] d,
                          int w, int b, int h, bit noise);
        int exp_pre, pre, stb, post, cyc;
        bit seen, got_done;
        bit bad_kind, bad_saddr, bad_sdoe, bad_dout, bad_paddr, bad_pdoe,
            bad_hold, bad_rdy;
        pre = 0; stb = 0; post = 0; cyc = 0;
        seen = 0; got_done = 0;
        bad_kind = 0; bad_saddr = 0; bad_sdoe = 0; bad_dout = 0;
        bad_paddr = 0; bad_pdoe = 0; bad_hold = 0; bad_rdy = 0;
        exp_pre = (!wr && prev_rd) ? h : ((wr && prev_rd) ? 1 : 0);

        chk("R7", "ready before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        if (noise) begin
            // R7: conflicting request held while busy must be ignored
            req_write = ~wr; req_addr = ~a; req_wdata = ~d;
        end else begin
            req_valid = 1'b0;
        end
        while (cyc < 200) begin
            cyc++;
            if (rsp_done) begin
                got_done = 1;
                break;
            end
            if (req_ready) bad_rdy = 1;
            if (!mem_rd_n || !mem_wr_n) begin
                stb++; seen = 1;
                if (mem_rd_n != wr || mem_wr_n != !wr || mem_sel_n) bad_kind = 1;
                if (mem_addr !== a) bad_saddr = 1;
                if (mem_doe != wr) bad_sdoe = 1;
                if (wr && mem_dout !== d) bad_dout = 1;
            end else if (!seen) begin
                pre++;
                if (mem_addr !== prev_addr) bad_paddr = 1;
                if (mem_doe || !mem_sel_n) bad_pdoe = 1;
            end else begin
                post++;
                if (mem_addr !== a || mem_doe != wr || !mem_sel_n) bad_hold = 1;
                if (wr && mem_dout !== d) bad_dout = 1;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;

        chk("R7", "done reached", {31'd0, got_done}, 32'd1);
        chk("R7", "ready low while busy", {31'd0, bad_rdy}, 32'd0);
        chk("R7", "ready with done", {31'd0, req_ready}, 32'd1);
        chk(wr ? "R3" : "R2", "strobe width", stb, w + 1);
        chk(wr ? "R3" : "R2", "strobe kind and select", {31'd0, bad_kind}, 32'd0);
        chk("R8", "address in strobe", {31'd0, bad_saddr}, 32'd0);
        chk("R3", "output enable in strobe", {31'd0, bad_sdoe}, 32'd0);
        chk("R3", "write data", {31'd0, bad_dout}, 32'd0);
        chk("R4", "bus hold length", post, b);
        chk("R4", "bus hold signals", {31'd0, bad_hold}, 32'd0);
        if (wr) chk("R6", "turnaround length", pre, exp_pre);
        else    chk("R5", "read hold length", pre, exp_pre);
        chk(wr ? "R6" : "R5", "lead-in address kept", {31'd0, bad_paddr}, 32'd0);
        chk(wr ? "R6" : "R5", "lead-in quiet", {31'd0, bad_pdoe}, 32'd0);
        if (!wr) chk("R2", "read data", rsp_rdata, {a[7:0] ^ 8'h5A, a});

        prev_rd = !wr;
        prev_addr = a;
    endtask

    initial begin
        #2_000_000;
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [31:0] filler;
        int k;
        filler = ~((32'd7 << 18) | (32'd7 << 11) | (32'd31 << 6));
        k = 0;
        repeat (3) @(negedge clk);
        // R1 while reset held
        chk("R1", "ready in reset", {31'd0, req_ready}, 32'd1);
        chk("R1", "strobes in reset", {29'd0, mem_sel_n, mem_rd_n, mem_wr_n}, 32'd7);
        chk("R1", "doe and done in reset", {30'd0, mem_doe, rsp_done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after reset", {27'd0, req_ready, mem_sel_n, mem_rd_n,
            mem_wr_n, mem_doe | rsp_done}, 32'h1E);

        for (int w = 0; w < 4; w++) begin
            for (int b = 0; b < 3; b++) begin
                for (int h = 0; h < 3; h++) begin
                    cfg_word = filler | (32'(h) << 18) | (32'(b) << 11) | (32'(w) << 6);
                    for (int s = 0; s < 6; s++) begin
                        bit op;
                        op = (s == 2 || s == 3 || s == 5);
                        k++;
                        access(op, 24'(k * 24'h012345 + 24'(s)),
                               32'hC0DE0000 ^ 32'(k), w, b, h, k[0]);
                    end
                end
            end
        end

        @(negedge clk);
        chk("R7", "done single pulse", {31'd0, rsp_done}, 32'd0);
        chk("R7", "idle after sweep", {29'd0, req_ready, mem_rd_n, mem_wr_n}, 32'd7);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule